// File: doc/BRIEF.md
# Residue Channel Multiply-Accumulate Unit

This block is a single lane of a parallel residue-number-system arithmetic engine. It holds a small local operand memory and two wide accumulators, and computes products, sums of products and differences of products, all modulo its own lane modulus `2^W - C`. A global sequencer, which is outside this block, issues one command per cycle to every lane at once. The command gives an operation, an accumulator select, an operand source and three memory addresses. The sequencer also supplies a broadcast value (`xi_i`) and a lane-specific constant (`kconst_i`).

The two accumulators can be updated by different commands. This lets the real and imaginary halves of a product over the quadratic extension with `i^2 = -1` build up side by side: `x0*y0 - x1*y1` goes into one accumulator and `x0*y1 + x1*y0` into the other. Subtraction never drives an accumulator negative, because a fixed multiple of the modulus is added with it. Sums are kept unreduced until a reduce command is issued. That command folds the selected accumulator down to a canonical residue, writes it back to local memory and drives it onto the outgoing broadcast bus. A multiply-by-small-constant path scales a memory operand by 2, 3, 4 or 6 without using the wide multiplier.

Top module: `rns_channel`

## Requirements
- R1: After synchronous reset, `wr_en_o` is 0, `xi_o` is 0, and both accumulators hold 0, so a reduce of either one yields 0.
- R2: Opcode 1 (load) writes `xi_i` to memory at `wa_i`. One cycle later, `wr_en_o`=1, `wr_addr_o`=`wa_i` and `wr_data_o`=`xi_i`.
- R3: Opcode 2 (multiply) replaces the selected accumulator with A*B and discards its previous content. A is the memory word at `ra_i`.
- R4: Opcode 3 (multiply-add) adds A*B to the selected accumulator.
- R5: Opcode 4 (multiply-subtract) lowers the selected accumulator by A*B modulo the lane modulus. The result is correct even when the true integer difference is negative.
- R6: Opcode 5 (constant scale) adds k*A to the selected accumulator. `kcode_i` selects k: 0 gives 2, 1 gives 3, 2 gives 4 and 3 gives 6.
- R7: Operand B comes from the source named by `bsrc_i`. Value 0 selects memory at `rb_i`, 1 selects `xi_i`, and 2 or 3 select `kconst_i`.
- R8: Opcode 6 (reduce) writes the selected accumulator modulo `2^W - C` to memory at `wa_i`. One cycle later, it shows that value on `wr_data_o` and `xi_o` with `wr_en_o`=1 and `wr_addr_o`=`wa_i`. The value is always below the modulus, and the accumulator is left unchanged.
- R9: `acc_sel_i` chooses accumulator 0 or 1. A command never changes the accumulator that it does not select.
- R10: At least 20 full-size products, added or subtracted in any mix, accumulate without loss, and a reduce afterwards still gives the exact residue.
- R11: `xi_o` changes only one cycle after a reduce. `wr_en_o` is 0 one cycle after any command other than load or reduce, including opcodes 0 and 7.
- R12: A residue written by a reduce can be read as an operand by the very next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Command opcode |
| acc_sel_i | input | 1 | Accumulator select |
| bsrc_i | input | 2 | Source of operand B |
| kcode_i | input | 2 | Small-constant select for opcode 5 |
| ra_i | input | ABW | Memory read address for operand A |
| rb_i | input | ABW | Memory read address for operand B |
| wa_i | input | ABW | Memory write address |
| xi_i | input | W | Broadcast value from other lanes or the sequencer |
| kconst_i | input | W | Lane-specific constant |
| wr_en_o | output | 1 | Memory write happened on the previous command |
| wr_addr_o | output | ABW | Address of that write |
| wr_data_o | output | W | Data of that write |
| xi_o | output | W | Last reduced residue, driven onto the broadcast bus |

## Verification
The main stimulus is a table of complex operand quadruples, each turned into a full quadratic-extension product. The table includes small numbers, whose differences go negative and so test the modulus offset on subtraction. It includes all-maximum residues, where every partial product is congruent to 1. It includes zeros, which expose stale accumulator content that a multiply should have cleared. It also includes mixed large values, which exercise every fold of the reducer. Directed cases follow the table. Sums of twenty maximal terms check accumulator headroom. Each scale constant and each operand-B source is tried on its own. Read-after-write of a reduced residue is checked, and so are the points where the broadcast output must hold still.

// File: rtl/rns_ch_pkg.sv
package rns_ch_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_MUL  = 3'd2,
        OP_MACP = 3'd3,
        OP_MACN = 3'd4,
        OP_CMUL = 3'd5,
        OP_RED  = 3'd6,
        OP_RSVD = 3'd7
    } op_e;

    typedef struct packed {
        op_e        op;
        logic       sel;
        logic [1:0] bsrc;
        logic [1:0] kcode;
    } cmd_t;

    // Small scale constant chosen by the 2-bit code.
    function automatic logic [2:0] small_k(input logic [1:0] code);
        case (code)
            2'd0:    small_k = 3'd2;
            2'd1:    small_k = 3'd3;
            2'd2:    small_k = 3'd4;
            default: small_k = 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/rns_ch_ram.sv
module rns_ch_ram #(
    parameter int W     = 36,
    parameter int DEPTH = 16,
    parameter int ABW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic [ABW-1:0] ra_i,
    input  logic [ABW-1:0] rb_i,
    output logic [W-1:0]   qa_o,
    output logic [W-1:0]   qb_o,
    input  logic           we_i,
    input  logic [ABW-1:0] wa_i,
    input  logic [W-1:0]   wd_i
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[wa_i] <= wd_i;
    end

    assign qa_o = mem[ra_i];
    assign qb_o = mem[rb_i];
endmodule

// File: rtl/rns_ch_acc.sv
module rns_ch_acc
    import rns_ch_pkg::*;
#(
    parameter int             W       = 36,
    parameter int             AW      = 2 * W + 6,
    parameter logic [AW-1:0]  SUB_OFS = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_t                 cmd_i,
    input  logic [W-1:0]         a_i,
    input  logic [W-1:0]         b_i,
    output logic [1:0][AW-1:0]   acc_o
);
    localparam int PW = 2 * W;
    localparam int KW = W + 3;

    logic [PW-1:0] prod;
    logic [KW-1:0] kprod;
    logic [KW-1:0] a_ext;

    // Wide multiplier.
    assign prod  = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    assign a_ext = KW'(a_i);

    // Shift-and-add scaling by 2, 3, 4 or 6.
    always_comb begin
        case (small_k(cmd_i.kcode))
            3'd2:    kprod = a_ext << 1;
            3'd3:    kprod = a_ext + (a_ext << 1);
            3'd4:    kprod = a_ext << 2;
            default: kprod = (a_ext << 1) + (a_ext << 2);
        endcase
    end

    for (genvar g = 0; g < 2; g++) begin : g_acc
        logic [AW-1:0] acc_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else if (cmd_i.sel == 1'(g)) begin
                case (cmd_i.op)
                    OP_MUL:  acc_q <= AW'(prod);
                    OP_MACP: acc_q <= acc_q + AW'(prod);
                    OP_MACN: acc_q <= acc_q + SUB_OFS - AW'(prod);
                    OP_CMUL: acc_q <= acc_q + AW'(kprod);
                    default: acc_q <= acc_q;
                endcase
            end
        end
        assign acc_o[g] = acc_q;
    end
endmodule

// File: rtl/rns_ch_reduce.sv
module rns_ch_reduce #(
    parameter int W  = 36,
    parameter int C  = 5,
    parameter int AW = 2 * W + 6
) (
    input  logic [AW-1:0] x_i,
    output logic [W-1:0]  r_o
);
    localparam int            NFOLD = 3;
    localparam int            HW    = AW - W;
    localparam logic [W-1:0]  MOD   = {W{1'b1}} - W'(C - 1);

    logic [AW-1:0] stage [NFOLD+1];
    assign stage[0] = x_i;

    // Each fold uses 2^W == C (mod 2^W - C).
    for (genvar f = 0; f < NFOLD; f++) begin : g_fold
        logic [HW-1:0] hi;
        logic [W-1:0]  lo;
        assign hi           = stage[f][AW-1:W];
        assign lo           = stage[f][W-1:0];
        assign stage[f + 1] = AW'(hi) * AW'(C) + AW'(lo);
    end

    logic [W-1:0] last;
    assign last = stage[NFOLD][W-1:0];
    assign r_o  = (last >= MOD) ? last - MOD : last;
endmodule

// File: rtl/rns_channel.sv
module rns_channel
    import rns_ch_pkg::*;
#(
    parameter int W     = 36,
    parameter int C     = 5,
    parameter int DEPTH = 16,
    parameter int GUARD = 5,
    parameter int ABW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     op_i,
    input  logic           acc_sel_i,
    input  logic [1:0]     bsrc_i,
    input  logic [1:0]     kcode_i,
    input  logic [ABW-1:0] ra_i,
    input  logic [ABW-1:0] rb_i,
    input  logic [ABW-1:0] wa_i,
    input  logic [W-1:0]   xi_i,
    input  logic [W-1:0]   kconst_i,
    output logic           wr_en_o,
    output logic [ABW-1:0] wr_addr_o,
    output logic [W-1:0]   wr_data_o,
    output logic [W-1:0]   xi_o
);
    localparam int            AW      = 2 * W + 1 + GUARD;
    localparam logic [W-1:0]  MOD     = {W{1'b1}} - W'(C - 1);
    localparam logic [AW-1:0] SUB_OFS = AW'(MOD) << (W + 1);

    cmd_t              cmd;
    logic [W-1:0]      qa, qb, opb, red_val, wdata;
    logic              we;
    logic [1:0][AW-1:0] acc;

    assign cmd.op    = op_e'(op_i);
    assign cmd.sel   = acc_sel_i;
    assign cmd.bsrc  = bsrc_i;
    assign cmd.kcode = kcode_i;

    assign opb = bsrc_i[1] ? kconst_i : (bsrc_i[0] ? xi_i : qb);

    assign we    = (cmd.op == OP_LOAD) || (cmd.op == OP_RED);
    assign wdata = (cmd.op == OP_LOAD) ? xi_i : red_val;

    rns_ch_ram #(.W(W), .DEPTH(DEPTH), .ABW(ABW)) ram_i (
        .clk  (clk),
        .ra_i (ra_i),
        .rb_i (rb_i),
        .qa_o (qa),
        .qb_o (qb),
        .we_i (we),
        .wa_i (wa_i),
        .wd_i (wdata)
    );

    rns_ch_acc #(.W(W), .AW(AW), .SUB_OFS(SUB_OFS)) acc_i (
        .clk   (clk),
        .rst   (rst),
        .cmd_i (cmd),
        .a_i   (qa),
        .b_i   (opb),
        .acc_o (acc)
    );

    rns_ch_reduce #(.W(W), .C(C), .AW(AW)) red_i (
        .x_i (acc[acc_sel_i]),
        .r_o (red_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            xi_o      <= '0;
        end else begin
            wr_en_o <= we;
            if (we) begin
                wr_addr_o <= wa_i;
                wr_data_o <= wdata;
            end
            if (cmd.op == OP_RED) xi_o <= red_val;
        end
    end
endmodule

// File: rtl/rns_channel_chk.sv
module rns_channel_chk
    import rns_ch_pkg::*;
#(
    parameter int            W    = 36,
    parameter int            ABW  = 4,
    parameter logic [W-1:0]  MODV = '1
) (
    input logic           clk,
    input logic           rst,
    input logic [2:0]     op_i,
    input logic [ABW-1:0] wa_i,
    input logic [W-1:0]   xi_i,
    input logic           wr_en_o,
    input logic [ABW-1:0] wr_addr_o,
    input logic [W-1:0]   wr_data_o,
    input logic [W-1:0]   xi_o
);
    AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LOAD) |=> (wr_en_o && wr_data_o == $past(xi_i) && wr_addr_o == $past(wa_i))); // R2

    AST_RED_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_RED) |=> (xi_o < MODV)); // R8

    AST_RED_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_RED) |=> (wr_en_o && wr_data_o == xi_o && wr_addr_o == $past(wa_i))); // R8

    AST_QUIET_OTHER: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_LOAD && op_i != OP_RED) |=> !wr_en_o); // R11

    AST_XI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_RED) |=> $stable(xi_o)); // R11
endmodule

bind rns_channel rns_channel_chk #(.W(W), .ABW(ABW), .MODV(MOD)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .wa_i      (wa_i),
    .xi_i      (xi_i),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .xi_o      (xi_o)
);

// File: tb/rns_channel_tb.sv
module rns_channel_tb_top;
    localparam int W   = 36;
    localparam int ABW = 4;
    localparam logic [127:0] M = (128'd1 << 36) - 128'd5;
    localparam logic [W-1:0] MX = 36'hFFFFFFFFA; // M - 1

    localparam logic [2:0] NOP = 3'd0, LOAD = 3'd1, MUL = 3'd2, MACP = 3'd3,
                           MACN = 3'd4, CMUL = 3'd5, RED = 3'd6, RSVD = 3'd7;

    localparam int NV = 6;
    localparam logic [W-1:0] VEC [NV][4] = '{
        '{36'd1,          36'd2,          36'd3,          36'd4},
        '{MX,             MX,             MX,             MX},
        '{36'd0,          MX,             36'd5,          36'd0},
        '{36'h123456789,  36'hABCDEF012,  36'h0FEDCBA98,  36'h876543210},
        '{MX,             36'd0,          36'd0,          MX},
        '{36'h800000000,  36'h7FFFFFFFF,  36'd1,          36'hFFFFFFF00}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2:0]     op_i = NOP;
    logic           acc_sel_i = 1'b0;
    logic [1:0]     bsrc_i = 2'd0, kcode_i = 2'd0;
    logic [ABW-1:0] ra_i = '0, rb_i = '0, wa_i = '0;
    logic [W-1:0]   xi_i = '0, kconst_i = '0;
    logic           wr_en_o;
    logic [ABW-1:0] wr_addr_o;
    logic [W-1:0]   wr_data_o, xi_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rns_channel dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .acc_sel_i(acc_sel_i), .bsrc_i(bsrc_i),
        .kcode_i(kcode_i), .ra_i(ra_i), .rb_i(rb_i), .wa_i(wa_i), .xi_i(xi_i),
        .kconst_i(kconst_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .xi_o(xi_o)
    );

    function automatic logic [127:0] mm(input logic [127:0] a, input logic [127:0] b);
        return (a * b) % M;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic sel, input logic [1:0] bs,
                        input logic [1:0] k, input logic [3:0] ra, input logic [3:0] rb,
                        input logic [3:0] wa, input logic [W-1:0] xi);
        @(negedge clk);
        op_i = op; acc_sel_i = sel; bsrc_i = bs; kcode_i = k;
        ra_i = ra; rb_i = rb; wa_i = wa; xi_i = xi;
        @(posedge clk);
        #1;
        op_i = NOP;
    endtask

    task automatic load(input logic [3:0] wa, input logic [W-1:0] v);
        step(LOAD, 1'b0, 2'd0, 2'd0, 4'd0, 4'd0, wa, v);
    endtask

    task automatic red_chk(input logic sel, input logic [3:0] wa, input logic [127:0] exp,
                           input string req);
        step(RED, sel, 2'd0, 2'd0, 4'd0, 4'd0, wa, '0);
        check(wr_en_o && wr_addr_o == wa && 128'(wr_data_o) == exp && 128'(xi_o) == exp,
              req, 128'(wr_data_o), exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] e;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs after reset
        check(!wr_en_o && xi_o == '0, "R1", 128'(xi_o), 128'd0);
        @(negedge clk);
        rst = 1'b0;
        red_chk(1'b0, 4'd14, 128'd0, "R1 acc0");
        red_chk(1'b1, 4'd15, 128'd0, "R1 acc1");

        // Table: quadratic-extension products (R3 R4 R5 R8 R9)
        for (int v = 0; v < NV; v++) begin
            load(4'd0, VEC[v][0]);
            check(wr_en_o && wr_addr_o == 4'd0 && wr_data_o == VEC[v][0], "R2",
                  128'(wr_data_o), 128'(VEC[v][0]));
            load(4'd1, VEC[v][1]);
            load(4'd2, VEC[v][2]);
            load(4'd3, VEC[v][3]);
            step(MUL,  1'b0, 2'd0, 2'd0, 4'd0, 4'd2, 4'd0, '0);
            step(MACN, 1'b0, 2'd0, 2'd0, 4'd1, 4'd3, 4'd0, '0);
            step(MUL,  1'b1, 2'd0, 2'd0, 4'd0, 4'd3, 4'd0, '0);
            step(MACP, 1'b1, 2'd0, 2'd0, 4'd1, 4'd2, 4'd0, '0);
            e = (mm(VEC[v][0], VEC[v][2]) + M - mm(VEC[v][1], VEC[v][3])) % M;
            red_chk(1'b0, 4'd8, e, "R5 R9 real part");
            e = (mm(VEC[v][0], VEC[v][3]) + mm(VEC[v][1], VEC[v][2])) % M;
            red_chk(1'b1, 4'd9, e, "R4 R9 imag part");
        end

        // R8: reduce leaves the accumulator unchanged
        red_chk(1'b1, 4'd10, e, "R8 repeat reduce");

        // R11: xi_o holds and wr_en low for non-write opcodes
        step(MUL, 1'b0, 2'd0, 2'd0, 4'd0, 4'd0, 4'd0, '0);
        check(!wr_en_o && 128'(xi_o) == e, "R11 after MUL", 128'(xi_o), e);
        load(4'd11, 36'd77);
        check(128'(xi_o) == e, "R11 after LOAD", 128'(xi_o), e);
        step(RSVD, 1'b0, 2'd0, 2'd0, 4'd0, 4'd0, 4'd11, 36'd99);
        check(!wr_en_o && 128'(xi_o) == e, "R11 opcode 7", 128'(xi_o), e);

        // R10: twenty maximal products added
        load(4'd4, MX);
        load(4'd5, 36'd1);
        step(MUL, 1'b0, 2'd0, 2'd0, 4'd4, 4'd4, 4'd0, '0);
        for (int i = 0; i < 19; i++) step(MACP, 1'b0, 2'd0, 2'd0, 4'd4, 4'd4, 4'd0, '0);
        red_chk(1'b0, 4'd12, 128'd20, "R10 twenty adds");
        // R10 + R5: twenty maximal products subtracted from 2*1
        load(4'd6, 36'd2);
        step(MUL, 1'b1, 2'd0, 2'd0, 4'd6, 4'd5, 4'd0, '0);
        for (int i = 0; i < 20; i++) step(MACN, 1'b1, 2'd0, 2'd0, 4'd4, 4'd4, 4'd0, '0);
        red_chk(1'b1, 4'd12, M - 128'd18, "R10 twenty subtracts");
        // R5: small negative difference 2 - (M-1)^2 == 1
        step(MUL,  1'b0, 2'd0, 2'd0, 4'd6, 4'd5, 4'd0, '0);
        step(MACN, 1'b0, 2'd0, 2'd0, 4'd4, 4'd4, 4'd0, '0);
        red_chk(1'b0, 4'd12, 128'd1, "R5 negative difference");

        // R6: each scale code adds k*A to A*1
        for (int k = 0; k < 4; k++) begin
            logic [127:0] kv;
            kv = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 4 : 6;
            step(MUL,  1'b0, 2'd0, 2'd0, 4'd4, 4'd5, 4'd0, '0);
            step(CMUL, 1'b0, 2'd0, 2'(k), 4'd4, 4'd0, 4'd0, '0);
            red_chk(1'b0, 4'd13, ((kv + 1) * 128'(MX)) % M, "R6 scale code");
        end

        // R7: operand B sources
        kconst_i = 36'h00ABCDEF1;
        step(MUL, 1'b0, 2'd1, 2'd0, 4'd6, 4'd0, 4'd0, 36'h555555555);
        red_chk(1'b0, 4'd13, mm(2, 36'h555555555), "R7 broadcast source");
        step(MUL, 1'b0, 2'd2, 2'd0, 4'd6, 4'd0, 4'd0, 36'h555555555);
        red_chk(1'b0, 4'd13, mm(2, 36'h00ABCDEF1), "R7 constant source");
        step(MUL, 1'b0, 2'd3, 2'd0, 4'd6, 4'd0, 4'd0, 36'h555555555);
        red_chk(1'b0, 4'd13, mm(2, 36'h00ABCDEF1), "R7 code 3 source");

        // R9: acc1 untouched while acc0 changes
        step(MUL, 1'b1, 2'd0, 2'd0, 4'd6, 4'd6, 4'd0, '0);
        step(MUL, 1'b0, 2'd0, 2'd0, 4'd4, 4'd4, 4'd0, '0);
        step(MACP, 1'b0, 2'd0, 2'd0, 4'd4, 4'd6, 4'd0, '0);
        red_chk(1'b1, 4'd13, 128'd4, "R9 acc1 isolated");

        // R12: reduced residue read by the next command
        step(MUL, 1'b0, 2'd0, 2'd0, 4'd0, 4'd1, 4'd0, '0);
        e = mm(VEC[NV-1][0], VEC[NV-1][1]);
        red_chk(1'b0, 4'd7, e, "R12 write");
        step(MUL, 1'b1, 2'd0, 2'd0, 4'd7, 4'd6, 4'd0, '0);
        red_chk(1'b1, 4'd7, (e * 2) % M, "R12 read-after-write");

        // R1: reset clears outputs and accumulators
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(!wr_en_o && xi_o == '0, "R1 re-reset", 128'(xi_o), 128'd0);
        @(negedge clk);
        rst = 1'b0;
        red_chk(1'b1, 4'd14, 128'd0, "R1 acc cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule